// File: doc/BRIEF.md
# Clock Output Selector with Programmable Divider

This block drives a clock output pin. It chooses one of several source clocks with a small select field. It then either holds the result low, passes it straight through, or divides it by a programmable integer ratio from 2 to 15. Every divided waveform has a 50% duty cycle, including odd ratios. For odd ratios the block uses a register clocked on the falling edge, so the high time is half of an odd number of source periods.

A chip normally carries two copies of the block, and each has its own source list. In the five-source copy, index 0 is the internal high-speed RC oscillator, 1 the low-speed crystal, 2 the high-speed crystal, 3 the first PLL's Q tap and 4 the 48 MHz RC oscillator. In the six-source copy, index 0 is the system clock, 1 the second PLL's P tap, 2 the high-speed crystal, 3 the first PLL's P tap, 4 the low-power RC oscillator and 5 the low-speed RC oscillator. Select and divider codes are meant to be written once after reset. Changing them while the output runs can glitch the output, and the block makes no attempt to prevent that.

Top module: `clkout_sel_div`

## Requirements
- R1: While `rst_n` is low, `clk_out` is held low whatever the select and divider codes are.
- R2: Divider code 0 holds `clk_out` low. This is the disabled setting, and software leaves it in place after reset.
- R3: Divider code 1 passes the selected source to `clk_out` undivided: same period, same high time.
- R4: A divider code N from 2 to 15 makes `clk_out` periodic with a period of exactly N periods of the selected source. The internal phase counter never exceeds N-1 and wraps to zero.
- R5: For every divider code N from 2 to 15, the high time of `clk_out` is N/2 source periods (50% duty), odd N included.
- R6: A select code k below `NUM_SRC` picks bit k of `src_clk` as the source, so the source order of each instance is the bit order of its `src_clk` port.
- R7: A select code at or above `NUM_SRC` is reserved and holds `clk_out` low.
- R8: A change of the divider code restarts the divider. The next source rising edge loads the new code. For even N the output then rises on the rising edge after that. For odd N it rises half a source period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_clk | input | NUM_SRC | Candidate source clocks; bit k is chosen by select code k |
| sel | input | SEL_W | Source select code |
| pre | input | PRE_W | Divider code: 0 off, 1 bypass, 2..15 divide ratio |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_out | output | 1 | Divided output clock |

## Verification
A wrong phase count shows up as a wrong `clk_out` period in the first full output period after the divider loads its code. A falling-edge register that is out of phase shows up as an odd-ratio high time that is half a source period too long or too short, on the first odd-ratio measurement. A wrong restart value moves the first output rising edge after a code change by whole source periods. The bench times that edge directly. A mistake in the source decode or the reserved-code gating shows up at once as the wrong period, or as edges where the output must stay silent.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;

  // Divider code semantics: 0 disabled, 1 bypass, >=2 divide by code.
  localparam int DIV_OFF    = 0;
  localparam int DIV_BYPASS = 1;

  function automatic bit div_active(input int code);
    return code >= 2;
  endfunction

  // Last phase index of one output period (0 when the divider is idle).
  function automatic int div_last(input int code);
    return div_active(code) ? code - 1 : 0;
  endfunction

  // Number of source periods the rising-edge phase flag stays high.
  function automatic int div_half(input int code);
    return (code + 1) / 2;
  endfunction

  function automatic bit div_is_odd(input int code);
    return div_active(code) && (code % 2 == 1);
  endfunction

endpackage

// File: rtl/clkout_src_mux.sv
`timescale 1ns/1ps
module clkout_src_mux #(
  parameter int NUM_SRC = 6,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0]   sel,
  output logic               sel_clk,
  output logic               sel_valid
);

  logic [NUM_SRC-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_hit
      assign hit[gi] = (sel == SEL_W'(gi));
    end
  endgenerate

  // Reserved codes match no source, so the clock collapses to 0.
  assign sel_clk   = |(hit & src_clk);
  assign sel_valid = |hit;

endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider #(
  parameter int PRE_W = 4
) (
  input  logic             div_clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] code,
  output logic             div_out,
  output logic             restart_ev,
  output logic             wrap_ev
);
  import clkout_pkg::*;

  logic [PRE_W-1:0] code_q;
  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] cnt_nxt;
  logic [PRE_W-1:0] last_idx;
  logic [PRE_W-1:0] half_len;
  logic [PRE_W-1:0] load_idx;
  logic             active;
  logic             odd_mode;
  logic             rise_q;
  logic             fall_q;

  assign active     = div_active(int'(code_q));
  assign odd_mode   = div_is_odd(int'(code_q));
  assign last_idx   = PRE_W'(div_last(int'(code_q)));
  assign half_len   = PRE_W'(div_half(int'(code_q)));
  assign load_idx   = PRE_W'(div_last(int'(code)));
  assign restart_ev = (code != code_q);
  assign wrap_ev    = active && !restart_ev && (cnt >= last_idx);
  assign cnt_nxt    = (cnt >= last_idx) ? '0 : cnt + 1'b1;

  // Rising-edge phase counter and high-phase flag.
  always_ff @(posedge div_clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt    <= '0;
      rise_q <= 1'b0;
    end else if (restart_ev) begin
      code_q <= code;
      cnt    <= load_idx;
      rise_q <= 1'b0;
    end else if (active) begin
      cnt    <= cnt_nxt;
      rise_q <= (cnt_nxt < half_len);
    end
  end

  // Half-period delayed copy for odd ratios.
  always_ff @(negedge div_clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= rise_q;
  end

  assign div_out = odd_mode ? (rise_q & fall_q) : rise_q;

  // R4
  wrap_to_zero_chk: assert property (@(posedge div_clk) disable iff (!rst_n)
    wrap_ev |=> (cnt == '0) && rise_q);

  // R4
  cnt_bound_chk: assert property (@(posedge div_clk) disable iff (!rst_n)
    (active && !restart_ev) |-> (cnt <= last_idx));

  // R8
  restart_load_chk: assert property (@(posedge div_clk) disable iff (!rst_n)
    (restart_ev && div_active(int'(code))) |=>
      (cnt == PRE_W'($past(code) - 1'b1)) && !rise_q);

endmodule

// File: rtl/clkout_outstage.sv
`timescale 1ns/1ps
module clkout_outstage #(
  parameter int PRE_W = 4
) (
  input  logic             rst_n,
  input  logic             sel_clk,
  input  logic             sel_valid,
  input  logic             div_out,
  input  logic [PRE_W-1:0] code,
  output logic             clk_out
);
  import clkout_pkg::*;

  logic path_val;

  always_comb begin
    if (code == PRE_W'(DIV_BYPASS))      path_val = sel_clk;
    else if (div_active(int'(code)))     path_val = div_out;
    else                                 path_val = 1'b0;
  end

  assign clk_out = rst_n & sel_valid & path_val;

endmodule

// File: rtl/clkout_sel_div.sv
`timescale 1ns/1ps
module clkout_sel_div #(
  parameter int NUM_SRC = 6,
  parameter int SEL_W   = 3,
  parameter int PRE_W   = 4
) (
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0]   sel,
  input  logic [PRE_W-1:0]   pre,
  input  logic               rst_n,
  output logic               clk_out
);

  logic sel_clk;
  logic sel_valid;
  logic div_out;
  logic restart_ev;
  logic wrap_ev;

  clkout_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src_clk  (src_clk),
    .sel      (sel),
    .sel_clk  (sel_clk),
    .sel_valid(sel_valid)
  );

  clkout_divider #(.PRE_W(PRE_W)) u_div (
    .div_clk   (sel_clk),
    .rst_n     (rst_n),
    .code      (pre),
    .div_out   (div_out),
    .restart_ev(restart_ev),
    .wrap_ev   (wrap_ev)
  );

  clkout_outstage #(.PRE_W(PRE_W)) u_out (
    .rst_n    (rst_n),
    .sel_clk  (sel_clk),
    .sel_valid(sel_valid),
    .div_out  (div_out),
    .code     (pre),
    .clk_out  (clk_out)
  );

  // R2
  disabled_low_chk: assert property (@(posedge sel_clk) disable iff (!rst_n)
    (pre == '0) |-> !clk_out);

  // R3
  bypass_high_chk: assert property (@(negedge sel_clk) disable iff (!rst_n)
    (pre == PRE_W'(1) && sel_valid) |-> clk_out);

endmodule

// File: tb/clkout_sel_div_tb.sv
`timescale 1ns/1ps
module clkout_sel_div_tb;

  typedef struct {
    int    sel;
    int    code;
    bit    quiet;
    real   per;
    real   hi;
    string req_per;
    string req_hi;
  } exp_t;

  real per_ns [6] = '{8.0, 12.0, 10.0, 6.0, 14.0, 20.0};

  logic [5:0] src_clk = '0;
  logic [2:0] sel_i   = 3'd2;
  logic [3:0] pre_i   = 4'd3;
  logic       rst_n   = 1'b0;
  logic       clk_out;
  logic       out5;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  int edge5 = 0;
  bit finished = 0;
  exp_t q[$];
  event kick, done;

  // src_clk[0] is the 125 MHz bench clock
  always #4.0  src_clk[0] = ~src_clk[0];
  always #6.0  src_clk[1] = ~src_clk[1];
  always #5.0  src_clk[2] = ~src_clk[2];
  always #3.0  src_clk[3] = ~src_clk[3];
  always #7.0  src_clk[4] = ~src_clk[4];
  always #10.0 src_clk[5] = ~src_clk[5];

  clkout_sel_div #(.NUM_SRC(6)) u_dut (
    .src_clk(src_clk), .sel(sel_i), .pre(pre_i), .rst_n(rst_n), .clk_out(clk_out)
  );

  clkout_sel_div #(.NUM_SRC(5)) u_dut5 (
    .src_clk(src_clk[4:0]), .sel(sel_i), .pre(pre_i), .rst_n(rst_n), .clk_out(out5)
  );

  always @(posedge clk_out) edge_cnt++;
  always @(posedge out5)    edge5++;

  task automatic check_real(string req, string what, real got, real exp);
    checks++;
    if ((got - exp) > 0.01 || (exp - got) > 0.01) begin
      errors++;
      $display("FAIL %s %s: got %0.3f exp %0.3f", req, what, got, exp);
    end
  endtask

  task automatic check_int(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d exp %0d", req, what, got, exp);
    end
  endtask

  // Driver: program a setting and queue what the output must look like.
  task automatic apply(int s, int c, string rp, string rh);
    exp_t it;
    real t;
    pre_i = 4'd0;
    #40;
    sel_i = 3'(s);
    #40;
    pre_i = 4'(c);
    it.sel = s; it.code = c; it.req_per = rp; it.req_hi = rh;
    it.quiet = (c == 0) || (s >= 6);
    t = (s < 6) ? per_ns[s] : 0.0;
    it.per = (c <= 1) ? t : c * t;
    it.hi  = it.per / 2.0;
    q.push_back(it);
    -> kick;
    @(done);
  endtask

  // Monitor: pop the expectation and measure the waveform.
  initial begin
    forever begin
      exp_t it;
      real t0, t1, t2;
      int n0;
      @(kick);
      it = q.pop_front();
      if (it.quiet) begin
        n0 = edge_cnt;
        #400;
        check_int(it.req_per, $sformatf("edges sel=%0d code=%0d", it.sel, it.code),
                  edge_cnt - n0, 0);
        check_int(it.req_per, "level", int'(clk_out), 0);
      end else begin
        repeat (2) @(posedge clk_out);
        t0 = $realtime;
        @(negedge clk_out);
        t1 = $realtime;
        @(posedge clk_out);
        t2 = $realtime;
        check_real(it.req_per, $sformatf("period sel=%0d code=%0d", it.sel, it.code),
                   t2 - t0, it.per);
        check_real(it.req_hi, $sformatf("high sel=%0d code=%0d", it.sel, it.code),
                   t1 - t0, it.hi);
      end
      -> done;
    end
  end

  task automatic restart_case(int s, int c);
    real te, exp;
    pre_i = 4'd0;
    #40;
    sel_i = 3'(s);
    #40;
    @(posedge src_clk[s]);
    te = $realtime;
    #1;
    pre_i = 4'(c);
    exp = 2.0 * per_ns[s] + ((c % 2 == 1) ? per_ns[s] / 2.0 : 0.0);
    @(posedge clk_out);
    check_real("R8", $sformatf("first rise delay code=%0d", c), $realtime - te, exp);
  endtask

  initial begin
    int n0;
    // R1: reset holds output low with an active code
    #100;
    check_int("R1", "edges in reset", edge_cnt, 0);
    pre_i = 4'd1;
    #50;
    check_int("R1", "bypass in reset edges", edge_cnt, 0);
    check_int("R1", "level in reset", int'(clk_out), 0);
    pre_i = 4'd0;
    #20;
    rst_n = 1'b1;
    #40;

    apply(2, 0, "R2", "R2");
    apply(0, 1, "R3", "R3");
    apply(3, 1, "R3/R6", "R3");
    apply(1, 2, "R4/R6", "R5");
    apply(2, 3, "R4", "R5");
    apply(4, 4, "R4/R6", "R5");
    apply(5, 7, "R4/R6", "R5");
    apply(0, 15, "R4", "R5");
    apply(3, 8, "R4", "R5");
    apply(1, 9, "R4", "R5");
    apply(5, 15, "R4", "R5");
    apply(6, 3, "R7", "R7");
    apply(7, 5, "R7", "R7");

    restart_case(2, 4);
    restart_case(2, 5);
    restart_case(1, 2);

    // R7 on the five-source instance: code 5 reserved, code 4 valid
    pre_i = 4'd0; #40; sel_i = 3'd5; #40; pre_i = 4'd2;
    n0 = edge5;
    #300;
    check_int("R7", "five-source reserved edges", edge5 - n0, 0);
    pre_i = 4'd0; #40; sel_i = 3'd4; #40; pre_i = 4'd2;
    n0 = edge5;
    #300;
    checks++;
    if (edge5 - n0 < 5) begin
      errors++;
      $display("FAIL R6 five-source sel 4 edges: got %0d exp >= 5", edge5 - n0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule